// File: doc/BRIEF.md
# Watchdog Timer with Timed Configuration Unlock

This block is a watchdog counter with a small register port. Software picks one of ten timeout periods, from 16 ms up to 8 s, and switches the watchdog on. While it is on, the counter advances on a prescaled tick input and software must restart it with a kick strobe before it reaches the selected period. If the period runs out, the block raises a one-cycle system reset request and sets a sticky cause flag in a status register. The block's own reset input is taken to be a power-on reset that the reset request does not drive, so the flag survives the system reset.

The enable bit and the period select are guarded. A change takes two writes. The first sets the change-enable bit and the enable bit together and opens a short window. The second arrives inside that window with change-enable clear and carries the new settings. Any other write to the control register leaves the configuration as it was. While the cause flag is set, the enable bit stays at one, so the watchdog cannot be switched off until software has cleared the flag.

The parameter `TICKS_PER_MS` sets how many tick pulses make one millisecond, so a simulation can use short periods. `WIN_CYCLES` sets the length of the unlock window and defaults to four clocks.

Top module: `wdog_ctrl`

## Requirements
- R1: After reset, the control register (address 0) and the status register (address 1) both read 0, and `rst_req` is low.
- R2: Control bits [5:2] select the period. Codes 0..9 give 16, 32, 64, 125, 250, 500, 1000, 2000, 4000 and 8000 ms, and codes 10..15 give 8000 ms. The timeout is that period times `TICKS_PER_MS` ticks, counted from the restart that begins it.
- R3: Writing the control register with bit 1 (change-enable) and bit 0 (enable) both at 1 opens the unlock window. Bit 1 reads as 1 while the window is open. A write that has bit 1 set but bit 0 clear opens nothing.
- R4: A control write with bit 1 clear, made in any of the `WIN_CYCLES` cycles after the opening write, loads bit 0 as the enable and bits [5:2] as the period code, closes the window, and restarts the count from zero.
- R5: The window closes by itself after `WIN_CYCLES` cycles. A second-step write made later is ignored, while a new opening write starts a fresh window.
- R6: A control write made while the window is closed leaves the enable and the period code unchanged.
- R7: A kick while the watchdog is enabled restarts the count from zero, so the next expiry comes one full timeout after the kick.
- R8: The count advances only in cycles where `tick` is high. While the watchdog is disabled the count stays at zero and no reset request is made.
- R9: On expiry, `rst_req` is high for exactly one cycle, status bit 0 is set, and counting starts again from zero for as long as the watchdog stays enabled.
- R10: While status bit 0 is set, the enable stays at 1 and second-step writes cannot clear it. Writing 0 to status bit 0 clears the flag, and writing 1 to it has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 control, 1 status |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read address: 0 control, 1 status |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |
| kick | input | 1 | Restart strobe for the running count |
| tick | input | 1 | Prescaled time base, one count per high cycle |
| rst_req | output | 1 | One-cycle system reset request on expiry |

## Verification
The bound checker checks on every cycle that the reset request is a single-cycle pulse and is always followed by the cause flag. It also checks that the flag always holds the enable high, that the period code cannot change while the window is closed, and that a kick or a disabled state leaves the count at zero. Only the bench scenarios can show the actual timeout lengths. The bench sweeps all sixteen period codes and measures the cycles from configuration to reset request. It also measures the window's exact edge: a second step four cycles after the opening write is accepted, and one five cycles after is refused. It further covers the restart point after a kick, counting on a gated tick, and the order of flag clearing and disabling.

// File: rtl/wdg_pkg.sv
// Package: shared constants, register field positions and the period
// decode for the watchdog. Assumes an 8-bit register data path.
package wdg_pkg;

    // Control register field positions; the bench and software decode these.
    localparam int unsigned CTL_EN    = 0;
    localparam int unsigned CTL_CHG   = 1;
    localparam int unsigned CTL_PS_LO = 2;
    localparam int unsigned PS_W      = 4;
    localparam int unsigned STAT_FLAG = 0;

    // Longest selectable period in milliseconds.
    localparam int unsigned MAX_PERIOD_MS = 8000;

    // Register address decode.
    typedef enum logic {
        REG_CTRL = 1'b0,
        REG_STAT = 1'b1
    } wdg_reg_e;

    // Active configuration held by the unlock logic.
    typedef struct packed {
        logic            en;
        logic [PS_W-1:0] ps;
    } wdg_cfg_t;

    // Period in milliseconds for a period code; codes above 9 saturate.
    function automatic int unsigned period_ms(input logic [PS_W-1:0] code);
        int unsigned ms;
        case (code)
            4'd0:    ms = 16;
            4'd1:    ms = 32;
            4'd2:    ms = 64;
            4'd3:    ms = 125;
            4'd4:    ms = 250;
            4'd5:    ms = 500;
            4'd6:    ms = 1000;
            4'd7:    ms = 2000;
            4'd8:    ms = 4000;
            default: ms = MAX_PERIOD_MS;
        endcase
        return ms;
    endfunction

endpackage

// File: rtl/wdg_limit.sv
// Module: wdg_limit
// Turns the period code into the terminal count value (timeout ticks - 1).
// Assumes CNT_W holds MAX_PERIOD_MS * TICKS_PER_MS. The REG_OUT parameter
// selects a registered output. That costs one cycle after a code change,
// which is harmless because a code change also clears the counter.
module wdg_limit #(
    parameter int unsigned TICKS_PER_MS = 32,
    parameter int unsigned CNT_W        = 18,
    parameter bit          REG_OUT      = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [wdg_pkg::PS_W-1:0] ps,
    output logic [CNT_W-1:0]         last
);
    import wdg_pkg::*;

    logic [CNT_W-1:0] last_comb;

    // Decode the terminal count from the period table and the tick rate.
    always_comb begin
        last_comb = CNT_W'(period_ms(ps) * TICKS_PER_MS - 1);
    end

    generate
        if (REG_OUT) begin : g_reg
            logic [CNT_W-1:0] last_q;
            // Hold the decoded value for timing relief on wide counters.
            always_ff @(posedge clk) begin
                if (!rst_n) last_q <= CNT_W'(period_ms('0) * TICKS_PER_MS - 1);
                else        last_q <= last_comb;
            end
            assign last = last_q;
        end else begin : g_comb
            assign last = last_comb;
        end
    endgenerate

endmodule

// File: rtl/wdg_unlock.sv
// Module: wdg_unlock
// Holds the guarded configuration (enable and period code), the timed
// unlock window and the sticky expiry flag. A change needs an opening
// write (change-enable and enable both set), then a second write with
// change-enable clear within WIN_CYCLES clocks. Assumes the write
// strobes come already decoded by address and last a single cycle.
module wdg_unlock #(
    parameter int unsigned WIN_CYCLES = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_ctrl,
    input  logic                     wr_en_bit,
    input  logic                     wr_chg_bit,
    input  logic [wdg_pkg::PS_W-1:0] wr_ps,
    input  logic                     flag_clr,
    input  logic                     expire,
    output wdg_pkg::wdg_cfg_t        cfg,
    output logic                     win_open,
    output logic                     cfg_load,
    output logic                     flag
);
    import wdg_pkg::*;

    localparam int unsigned WIN_W = $clog2(WIN_CYCLES + 1);

    logic [WIN_W-1:0] win_cnt;
    logic             step_open;
    logic             step_commit;
    wdg_cfg_t         cfg_q;
    logic             flag_q;

    // Classify a control write as an opening step or a committing step.
    always_comb begin
        step_open   = wr_ctrl && wr_chg_bit && wr_en_bit;
        step_commit = wr_ctrl && !wr_chg_bit && (win_cnt != '0);
    end

    // Window timer: loaded by the opening step, cleared by a commit, else runs down.
    always_ff @(posedge clk) begin
        if (!rst_n)              win_cnt <= '0;
        else if (step_open)      win_cnt <= WIN_W'(WIN_CYCLES);
        else if (step_commit)    win_cnt <= '0;
        else if (win_cnt != '0)  win_cnt <= win_cnt - 1'b1;
    end

    // Configuration register: only a commit inside the window changes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (step_commit) begin
            cfg_q.en <= wr_en_bit | flag_q;
            cfg_q.ps <= wr_ps;
        end
    end

    // Sticky cause flag: set on expiry (set wins), cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (expire)   flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    assign cfg      = cfg_q;
    assign win_open = (win_cnt != '0);
    assign cfg_load = step_commit;
    assign flag     = flag_q;

endmodule

// File: rtl/wdg_count.sv
// Module: wdg_count
// Timeout counter. It counts tick cycles up to a terminal value and
// issues a registered one-cycle expiry pulse when the count wraps. A kick
// or a configuration load clears it; while disabled it rests at zero.
// Assumes 'last' stays stable between configuration loads.
module wdg_count #(
    parameter int unsigned CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             kick,
    input  logic             restart,
    input  logic [CNT_W-1:0] last,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;
    logic             exp_q;
    logic             at_end;

    // Terminal detection; >= guards against any stale larger count.
    always_comb begin
        at_end = (cnt_q >= last);
    end

    // Count ticks, with clearing by kick, reload or disable taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            exp_q <= 1'b0;
        end else begin
            exp_q <= 1'b0;
            if (!en || kick || restart) begin
                cnt_q <= '0;
            end else if (tick) begin
                if (at_end) begin
                    cnt_q <= '0;
                    exp_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign count  = cnt_q;
    assign expire = exp_q;

endmodule

// File: rtl/wdog_ctrl.sv
// Module: wdog_ctrl (top)
// Watchdog timer with a guarded control register and a status register.
// Address 0 is control: bit0 enable, bit1 change-enable (reads 1 while the
// unlock window is open), bits[5:2] period code. Address 1 is status: bit0
// sticky expiry flag, cleared by writing 0. Assumes rst_n is a power-on
// reset that rst_req does not drive, so the flag outlives a system reset.
module wdog_ctrl #(
    parameter int unsigned TICKS_PER_MS = 32,
    parameter int unsigned WIN_CYCLES   = 4,
    parameter int unsigned DATA_W       = 8,
    parameter bit          REG_LIMIT    = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              kick,
    input  logic              tick,
    output logic              rst_req
);
    import wdg_pkg::*;

    localparam int unsigned MAX_TICKS = MAX_PERIOD_MS * TICKS_PER_MS;
    localparam int unsigned CNT_W     = $clog2(MAX_TICKS);
    localparam int unsigned PS_HI     = CTL_PS_LO + PS_W - 1;

    logic             wr_ctrl;
    logic             flag_clr;
    wdg_cfg_t         cfg;
    logic             win_open;
    logic             cfg_load;
    logic             flag;
    logic             expire;
    logic [CNT_W-1:0] last;
    logic [CNT_W-1:0] count;
    logic             unused_hi;

    // Decode register writes by address.
    always_comb begin
        wr_ctrl  = wr_en && (wr_addr == REG_CTRL);
        flag_clr = wr_en && (wr_addr == REG_STAT) && !wr_data[STAT_FLAG];
    end

    assign unused_hi = ^wr_data[DATA_W-1:PS_HI+1];

    wdg_unlock #(
        .WIN_CYCLES (WIN_CYCLES)
    ) u_unlock (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctrl    (wr_ctrl),
        .wr_en_bit  (wr_data[CTL_EN]),
        .wr_chg_bit (wr_data[CTL_CHG]),
        .wr_ps      (wr_data[PS_HI:CTL_PS_LO]),
        .flag_clr   (flag_clr),
        .expire     (expire),
        .cfg        (cfg),
        .win_open   (win_open),
        .cfg_load   (cfg_load),
        .flag       (flag)
    );

    wdg_limit #(
        .TICKS_PER_MS (TICKS_PER_MS),
        .CNT_W        (CNT_W),
        .REG_OUT      (REG_LIMIT)
    ) u_limit (
        .clk   (clk),
        .rst_n (rst_n),
        .ps    (cfg.ps),
        .last  (last)
    );

    wdg_count #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cfg.en),
        .tick    (tick),
        .kick    (kick),
        .restart (cfg_load),
        .last    (last),
        .count   (count),
        .expire  (expire)
    );

    // Read mux: assemble the selected register image.
    always_comb begin
        rd_data = '0;
        if (rd_addr == REG_CTRL) begin
            rd_data[CTL_EN]            = cfg.en;
            rd_data[CTL_CHG]           = win_open;
            rd_data[PS_HI:CTL_PS_LO]   = cfg.ps;
        end else begin
            rd_data[STAT_FLAG]         = flag;
        end
    end

    assign rst_req = expire;

endmodule

// File: rtl/wdog_ctrl_chk.sv
// Module: wdog_ctrl_chk
// Property checker bound into every wdog_ctrl instance. It watches the
// reset request, the flag, the guarded configuration and the counter.
module wdog_ctrl_chk #(
    parameter int unsigned CNT_W = 18
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     rst_req,
    input logic                     flag,
    input logic                     en,
    input logic [wdg_pkg::PS_W-1:0] ps,
    input logic                     win_open,
    input logic                     kick,
    input logic [CNT_W-1:0]         count
);

    // R9: the reset request never lasts beyond one cycle.
    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R9: every reset request leaves the cause flag set.
    assert_flag_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> flag);

    // R10: a set flag always comes with the watchdog enabled.
    assert_flag_holds_en_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flag |-> en);

    // R6: a closed window keeps the period code unchanged.
    assert_cfg_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !win_open |=> $stable(ps));

    // R7: an enabled kick leaves the count at zero.
    assert_kick_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (kick && en) |=> (count == '0));

    // R8: a disabled watchdog keeps the count at zero and requests nothing.
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ((count == '0) && !rst_req));

endmodule

bind wdog_ctrl wdog_ctrl_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_req  (rst_req),
    .flag     (flag),
    .en       (cfg.en),
    .ps       (cfg.ps),
    .win_open (win_open),
    .kick     (kick),
    .count    (count)
);

// File: tb/test_wdog_ctrl.sv
// Bench for wdog_ctrl with one tick per millisecond, so a timeout equals
// its period in cycles. Expected periods are computed arithmetically.
module test_wdog_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_addr = 1'b0;
    logic [7:0] rd_data;
    logic       kick = 1'b0;
    logic       tick = 1'b1;
    logic       rst_req;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    wdog_ctrl #(
        .TICKS_PER_MS (1),
        .WIN_CYCLES   (4),
        .DATA_W       (8),
        .REG_LIMIT    (1'b0)
    ) i_wdog_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .kick    (kick),
        .tick    (tick),
        .rst_req (rst_req)
    );

    // Expected period: three doublings from 16, then doublings from 125, then 8000.
    function automatic int exp_period(input int code);
        if (code < 3)      return 16 << code;
        else if (code < 9) return 125 << (code - 3);
        else               return 8000;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic addr, input logic [7:0] data);
        wr_en = 1'b1; wr_addr = addr; wr_data = data;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic addr, output int val);
        rd_addr = addr;
        #0.1;
        val = int'(rd_data);
    endtask

    // Opening step, then commit of enable and code on the next cycle.
    task automatic configure(input logic en, input int code);
        wr(1'b0, 8'h03);
        wr(1'b0, {2'b00, 4'(code), 1'b0, en});
    endtask

    // Clear the flag, then disable.
    task automatic shutdown();
        wr(1'b1, 8'h00);
        configure(1'b0, 0);
    endtask

    // Cycles until rst_req is seen, capped.
    task automatic measure(output int n);
        n = 0;
        do begin
            cyc(1);
            n++;
        end while (!rst_req && n < 9000);
    endtask

    // Run n cycles and report whether rst_req appeared.
    task automatic watch(input int n, output int seen);
        seen = 0;
        for (int i = 0; i < n; i++) begin
            cyc(1);
            if (rst_req) seen = 1;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int v;
        int n;
        int seen;
        int ticks;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R1: reset state
        rd(1'b0, v); chk("R1 ctrl after reset", v, 0);
        rd(1'b1, v); chk("R1 status after reset", v, 0);
        chk("R1 rst_req after reset", int'(rst_req), 0);

        // R6: plain write with the window closed is ignored
        wr(1'b0, 8'h0D);
        rd(1'b0, v); chk("R6 plain ctrl write ignored", v, 0);

        // R3: change-enable without enable opens nothing
        wr(1'b0, 8'h02);
        rd(1'b0, v); chk("R3 opening without enable refused", v, 0);

        // R3: proper opening write shows change-enable
        wr(1'b0, 8'h03);
        rd(1'b0, v); chk("R3 window open readback", v, 8'h02);

        // R5: still open after three more cycles, closed after the fourth
        cyc(3);
        rd(1'b0, v); chk("R5 window open on last cycle", v, 8'h02);
        cyc(1);
        rd(1'b0, v); chk("R5 window self-closed", v, 0);
        wr(1'b0, 8'h0D);
        rd(1'b0, v); chk("R5 late commit (5 cycles) ignored", v, 0);

        // R4: commit on the fourth cycle after opening is accepted
        wr(1'b0, 8'h03);
        cyc(3);
        wr(1'b0, 8'h01);
        rd(1'b0, v); chk("R4 commit at window edge loads config", v, 8'h01);
        measure(n); chk("R4 count restarts at commit (code 0)", n, 16);

        // R9: counting resumes, flag set
        measure(n); chk("R9 second expiry after full period", n, 16);
        cyc(1);
        rd(1'b1, v); chk("R9 status flag set", v, 1);

        // R10: disable refused while flag set; 1 to the flag does nothing
        configure(1'b0, 0);
        rd(1'b0, v); chk("R10 enable held by flag", v, 8'h01);
        wr(1'b1, 8'h01);
        rd(1'b1, v); chk("R10 writing 1 keeps flag", v, 1);
        shutdown();
        rd(1'b1, v); chk("R10 flag cleared by writing 0", v, 0);
        rd(1'b0, v); chk("R10 disable after clearing", v, 0);

        // R8: disabled, no request over a long stretch
        watch(100, seen); chk("R8 no request while disabled", seen, 0);

        // R7: kick at ten cycles restarts the count
        configure(1'b1, 0);
        cyc(10);
        kick = 1'b1; cyc(1); kick = 1'b0;
        measure(n); chk("R7 expiry one period after kick", n, 16);
        shutdown();

        // R8: no ticks means no progress, then ticks every third cycle
        tick = 1'b0;
        configure(1'b1, 0);
        watch(40, seen); chk("R8 no request without ticks", seen, 0);
        ticks = 0;
        seen = 0;
        for (int i = 0; i < 200 && seen == 0; i++) begin
            tick = (i % 3 == 0);
            @(posedge clk);
            @(negedge clk);
            if (tick) ticks++;
            if (rst_req) seen = 1;
        end
        tick = 1'b1;
        chk("R8 expiry after counted ticks only", ticks, 16);
        shutdown();

        // R2: sweep every period code
        for (int code = 0; code < 16; code++) begin
            configure(1'b1, code);
            rd(1'b0, v); chk("R2 code readback", v, (code << 2) | 1);
            measure(n); chk("R2 timeout for code", n, exp_period(code));
            cyc(1);
            rd(1'b1, v); chk("R9 flag after sweep expiry", v, 1);
            shutdown();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule